// File: doc/BRIEF.md
# Register-Number Operand Bypass Selector

This block picks the source value for each register operand of the instruction in decode. Every in-flight result bus carries a valid flag, a write-enable, a no-forward flag, the destination register number, an ordering tag and the result data. The block matches each operand's register number directly against the register numbers on the buses. The tag is used for one thing only: to tell whether the most recent producer of the operand has arrived. When a bus matches, its data reaches the operand output in the same cycle.

Any matching value is latched, even one from a producer older than the most recent one. The operand keeps stalling until the most recent producer has either forwarded its value or completed. As a result, a later producer that suppresses its write does not wipe out a value that an earlier producer already forwarded. Results marked no-forward, such as reads of slow or performance-monitor special registers, are never taken from a bus. A consumer of such a result waits for the completion report. Register 0 is an ordinary register. A new instruction entering decode discards all latched state in the same cycle.

Top module: `opbyp_top`

## Requirements
- R1: When an operand's `op_req` is 0, or its `op_pending` is 0, `opnd_data` equals `rf_data` for that operand in the same cycle and `opnd_stall` is 0.
- R2: A bus entry qualifies for an operand when `bus_valid`=1, `bus_wen`=1, `bus_slow`=0 and `bus_reg` equals `op_reg`. Tags play no part in qualifying, and register 0 matches like any other register number.
- R3: While an operand has a pending producer and some bus entry qualifies, `opnd_data` shows that entry's data in the same cycle.
- R4: When several entries qualify in one cycle, the lowest bus index (the youngest producer) supplies the data.
- R5: A qualifying value is latched. In later cycles with no qualifying entry, `opnd_data` shows the latched value until the next `dec_new`.
- R6: With a pending producer, `opnd_stall` is 1 until a cycle in which either a qualifying entry carries a `bus_tag` equal to `op_tag`, or `cmp_valid`=1 with `cmp_tag` equal to `op_tag`. From that cycle on, `opnd_stall` stays 0 until `dec_new`.
- R7: An entry with `bus_wen`=0 neither forwards nor clears a latched value. When a first writer forwards and the most recent writer of the same register suppresses its write, the reader gets the first writer's result.
- R8: An entry with `bus_slow`=1 is never forwarded and never releases a stall, even when its tag matches. Only completion releases the stall.
- R9: A matching completion with `cmp_wen`=1 makes `opnd_data` equal `rf_data` from that cycle on. A matching completion with `cmp_wen`=0 leaves the latched value in use if one exists, and `rf_data` otherwise.
- R10: `dec_new`=1 discards the latched value and the released-stall state in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_new | input | 1 | A new instruction enters decode this cycle |
| op_req | input | NUM_OPS | Operand uses a register |
| op_pending | input | NUM_OPS | Operand has an in-flight producer |
| op_reg | input | NUM_OPS x REG_W | Source register number per operand |
| op_tag | input | NUM_OPS x TAG_W | Tag of the most recent producer per operand |
| rf_data | input | NUM_OPS x DATA_W | Register file read data per operand |
| bus_valid | input | NUM_BUS | Result bus entry valid (index 0 youngest) |
| bus_wen | input | NUM_BUS | Entry writes its destination |
| bus_slow | input | NUM_BUS | Entry must not be forwarded |
| bus_reg | input | NUM_BUS x REG_W | Destination register number |
| bus_tag | input | NUM_BUS x TAG_W | Producer tag |
| bus_data | input | NUM_BUS x DATA_W | Result data |
| cmp_valid | input | 1 | A producer completes |
| cmp_tag | input | TAG_W | Tag of the completing producer |
| cmp_wen | input | 1 | Completing producer wrote the register file |
| opnd_data | output | NUM_OPS x DATA_W | Selected operand value |
| opnd_stall | output | NUM_OPS | Operand not yet resolved |

## Verification
The bench sweeps every register number, including 0, against every combination of matching buses. A design with the wrong priority would show an older producer's data, and one that matched on tags would either forward the wrong register or ignore a correct match. Directed sequences cover four cases: a forward followed by a suppressed newer write, where a tag-only design would hand back the stale register file value; a no-forward entry with a matching tag, which a faulty design would release early or forward; a completion that writes, where an old latched value must not be reused; and a new instruction, which a faulty design would serve with the previous instruction's latched value.

// File: rtl/opbyp_pkg.sv
package opbyp_pkg;
   typedef enum logic [1:0] {
      SRC_RF    = 2'd0,
      SRC_BUS   = 2'd1,
      SRC_LATCH = 2'd2
   } opbyp_src_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/opbyp_match.sv
module opbyp_match #(
   parameter int unsigned NUM_BUS = 3,
   parameter int unsigned REG_W   = 5,
   parameter int unsigned TAG_W   = 4,
   parameter int unsigned DATA_W  = 64
) (
   input  logic [REG_W-1:0]                  want_reg,
   input  logic [TAG_W-1:0]                  want_tag,
   input  logic [NUM_BUS-1:0]                bus_valid,
   input  logic [NUM_BUS-1:0]                bus_wen,
   input  logic [NUM_BUS-1:0]                bus_slow,
   input  logic [NUM_BUS-1:0][REG_W-1:0]     bus_reg,
   input  logic [NUM_BUS-1:0][TAG_W-1:0]     bus_tag,
   input  logic [NUM_BUS-1:0][DATA_W-1:0]    bus_data,
   output logic                              any_hit,
   output logic                              recent_hit,
   output logic [DATA_W-1:0]                 hit_data
);
   logic [NUM_BUS-1:0] hit;
   logic [NUM_BUS-1:0] hit_recent;

   for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
      assign hit[b]        = bus_valid[b] & bus_wen[b] & ~bus_slow[b] &
                             (bus_reg[b] == want_reg);
      assign hit_recent[b] = hit[b] & (bus_tag[b] == want_tag);
   end

   // lowest index is the youngest producer and wins
   always_comb begin
      hit_data = '0;
      for (int b = NUM_BUS - 1; b >= 0; b--) begin
         if (hit[b]) hit_data = bus_data[b];
      end
   end

   assign any_hit    = |hit;
   assign recent_hit = |hit_recent;
endmodule

// File: rtl/opbyp_slot.sv
module opbyp_slot
   import opbyp_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_new,
   input  logic              need,
   input  logic              any_hit,
   input  logic              recent_hit,
   input  logic [DATA_W-1:0] hit_data,
   input  logic              cmp_hit,
   input  logic              cmp_wen,
   input  logic [DATA_W-1:0] rf_data,
   output logic [DATA_W-1:0] data,
   output logic              stall
);
   logic              lat_vld_q, done_q, rf_use_q;
   logic [DATA_W-1:0] lat_data_q;
   logic              lat_vld, done, rf_use, resolved;
   opbyp_src_e        src;

   assign lat_vld  = lat_vld_q & ~dec_new;
   assign done     = done_q    & ~dec_new;
   assign rf_use   = rf_use_q  & ~dec_new;
   assign resolved = done | recent_hit | cmp_hit;
   assign stall    = need & ~resolved;

   always_comb begin
      if (!need)                          src = SRC_RF;
      else if (any_hit)                   src = SRC_BUS;
      else if ((cmp_hit & cmp_wen) | rf_use) src = SRC_RF;
      else if (lat_vld)                   src = SRC_LATCH;
      else                                src = SRC_RF;
   end

   always_comb begin
      unique case (src)
         SRC_BUS:   data = hit_data;
         SRC_LATCH: data = lat_data_q;
         default:   data = rf_data;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_vld_q  <= 1'b0;
         done_q     <= 1'b0;
         rf_use_q   <= 1'b0;
         lat_data_q <= '0;
      end else begin
         lat_vld_q  <= lat_vld | any_hit;
         done_q     <= resolved;
         rf_use_q   <= (rf_use | (cmp_hit & cmp_wen)) & ~any_hit;
         if (any_hit) lat_data_q <= hit_data;
      end
   end
endmodule

// File: rtl/opbyp_top.sv
module opbyp_top #(
   parameter int unsigned NUM_OPS = 3,
   parameter int unsigned NUM_BUS = 3,
   parameter int unsigned REG_W   = 5,
   parameter int unsigned TAG_W   = 4,
   parameter int unsigned DATA_W  = 64
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           dec_new,
   input  logic [NUM_OPS-1:0]             op_req,
   input  logic [NUM_OPS-1:0]             op_pending,
   input  logic [NUM_OPS-1:0][REG_W-1:0]  op_reg,
   input  logic [NUM_OPS-1:0][TAG_W-1:0]  op_tag,
   input  logic [NUM_OPS-1:0][DATA_W-1:0] rf_data,
   input  logic [NUM_BUS-1:0]             bus_valid,
   input  logic [NUM_BUS-1:0]             bus_wen,
   input  logic [NUM_BUS-1:0]             bus_slow,
   input  logic [NUM_BUS-1:0][REG_W-1:0]  bus_reg,
   input  logic [NUM_BUS-1:0][TAG_W-1:0]  bus_tag,
   input  logic [NUM_BUS-1:0][DATA_W-1:0] bus_data,
   input  logic                           cmp_valid,
   input  logic [TAG_W-1:0]               cmp_tag,
   input  logic                           cmp_wen,
   output logic [NUM_OPS-1:0][DATA_W-1:0] opnd_data,
   output logic [NUM_OPS-1:0]             opnd_stall
);
   localparam int unsigned SEL_W = opbyp_pkg::idx_width(NUM_BUS);

   if (NUM_OPS < 1 || NUM_BUS < 1 || REG_W < 1 || TAG_W < 1 || DATA_W < 1 ||
       SEL_W > 8) begin : g_bad_cfg
      $error("opbyp_top: unsupported parameter set");
   end

   for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
      logic              any_hit, recent_hit, cmp_hit;
      logic [DATA_W-1:0] hit_data;

      assign cmp_hit = cmp_valid & (cmp_tag == op_tag[i]);

      opbyp_match #(
         .NUM_BUS(NUM_BUS), .REG_W(REG_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
      ) match_i (
         .want_reg   (op_reg[i]),
         .want_tag   (op_tag[i]),
         .bus_valid  (bus_valid),
         .bus_wen    (bus_wen),
         .bus_slow   (bus_slow),
         .bus_reg    (bus_reg),
         .bus_tag    (bus_tag),
         .bus_data   (bus_data),
         .any_hit    (any_hit),
         .recent_hit (recent_hit),
         .hit_data   (hit_data)
      );

      opbyp_slot #(.DATA_W(DATA_W)) slot_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .dec_new    (dec_new),
         .need       (op_req[i] & op_pending[i]),
         .any_hit    (any_hit),
         .recent_hit (recent_hit),
         .hit_data   (hit_data),
         .cmp_hit    (cmp_hit),
         .cmp_wen    (cmp_wen),
         .rf_data    (rf_data[i]),
         .data       (opnd_data[i]),
         .stall      (opnd_stall[i])
      );
   end
endmodule

// File: rtl/opbyp_chk.sv
module opbyp_chk #(
   parameter int unsigned NUM_OPS = 3,
   parameter int unsigned NUM_BUS = 3,
   parameter int unsigned REG_W   = 5,
   parameter int unsigned TAG_W   = 4,
   parameter int unsigned DATA_W  = 64
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           dec_new,
   input logic [NUM_OPS-1:0]             op_req,
   input logic [NUM_OPS-1:0]             op_pending,
   input logic [NUM_OPS-1:0][REG_W-1:0]  op_reg,
   input logic [NUM_OPS-1:0][TAG_W-1:0]  op_tag,
   input logic [NUM_OPS-1:0][DATA_W-1:0] rf_data,
   input logic [NUM_BUS-1:0]             bus_valid,
   input logic [NUM_BUS-1:0]             bus_wen,
   input logic [NUM_BUS-1:0]             bus_slow,
   input logic [NUM_BUS-1:0][REG_W-1:0]  bus_reg,
   input logic [NUM_BUS-1:0][DATA_W-1:0] bus_data,
   input logic                           cmp_valid,
   input logic [NUM_OPS-1:0][DATA_W-1:0] opnd_data,
   input logic [NUM_OPS-1:0]             opnd_stall
);
   for (genvar i = 0; i < NUM_OPS; i++) begin : g_chk
      // R1
      p_idle_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
         !(op_req[i] & op_pending[i]) |-> (!opnd_stall[i] && opnd_data[i] == rf_data[i]));

      // R4
      p_youngest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (op_req[i] & op_pending[i] & bus_valid[0] & bus_wen[0] & !bus_slow[0] &
          bus_reg[0] == op_reg[i]) |-> (opnd_data[i] == bus_data[0]));

      // R6
      p_release_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (op_req[i] & op_pending[i] & !opnd_stall[i])
         |=> (dec_new | !(op_req[i] & op_pending[i]) | !opnd_stall[i]));

      // R5
      p_hold_when_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!dec_new && bus_valid == '0 && !cmp_valid && $stable(op_req[i]) &&
          $stable(op_pending[i]) && $stable(op_reg[i]) && $stable(rf_data[i]) &&
          $past(!dec_new) && $past(bus_valid) == '0 && $past(!cmp_valid))
         |-> ($stable(opnd_data[i]) && $stable(opnd_stall[i])));
   end
endmodule

bind opbyp_top opbyp_chk #(
   .NUM_OPS(NUM_OPS), .NUM_BUS(NUM_BUS), .REG_W(REG_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .dec_new(dec_new), .op_req(op_req),
   .op_pending(op_pending), .op_reg(op_reg), .op_tag(op_tag), .rf_data(rf_data),
   .bus_valid(bus_valid), .bus_wen(bus_wen), .bus_slow(bus_slow), .bus_reg(bus_reg),
   .bus_data(bus_data), .cmp_valid(cmp_valid), .opnd_data(opnd_data),
   .opnd_stall(opnd_stall)
);

// File: tb/opbyp_top_tb_top.sv
module opbyp_top_tb_top;
   localparam int unsigned NO = 2;
   localparam int unsigned NB = 3;
   localparam int unsigned RW = 3;
   localparam int unsigned TW = 3;
   localparam int unsigned DW = 16;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic                   dec_new;
   logic [NO-1:0]          op_req, op_pending;
   logic [NO-1:0][RW-1:0]  op_reg;
   logic [NO-1:0][TW-1:0]  op_tag;
   logic [NO-1:0][DW-1:0]  rf_data;
   logic [NB-1:0]          bus_valid, bus_wen, bus_slow;
   logic [NB-1:0][RW-1:0]  bus_reg;
   logic [NB-1:0][TW-1:0]  bus_tag;
   logic [NB-1:0][DW-1:0]  bus_data;
   logic                   cmp_valid, cmp_wen;
   logic [TW-1:0]          cmp_tag;
   logic [NO-1:0][DW-1:0]  opnd_data;
   logic [NO-1:0]          opnd_stall;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   opbyp_top #(.NUM_OPS(NO), .NUM_BUS(NB), .REG_W(RW), .TAG_W(TW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .dec_new(dec_new), .op_req(op_req),
      .op_pending(op_pending), .op_reg(op_reg), .op_tag(op_tag), .rf_data(rf_data),
      .bus_valid(bus_valid), .bus_wen(bus_wen), .bus_slow(bus_slow), .bus_reg(bus_reg),
      .bus_tag(bus_tag), .bus_data(bus_data), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
      .cmp_wen(cmp_wen), .opnd_data(opnd_data), .opnd_stall(opnd_stall)
   );

   task automatic chk(input string req, input int op, input logic [DW-1:0] exp_d,
                      input logic exp_s);
      total++;
      if (opnd_data[op] !== exp_d || opnd_stall[op] !== exp_s) begin
         bad++;
         $display("FAIL %s op%0d: data=%h stall=%b expected data=%h stall=%b",
                  req, op, opnd_data[op], opnd_stall[op], exp_d, exp_s);
      end
   endtask

   task automatic quiet();
      dec_new   = 1'b0;
      bus_valid = '0; bus_wen = '0; bus_slow = '0;
      bus_reg   = '0; bus_tag = '0; bus_data = '0;
      cmp_valid = 1'b0; cmp_wen = 1'b0; cmp_tag = '0;
   endtask

   // step to the next drive point (after negedge)
   task automatic next();
      @(negedge clk);
      quiet();
   endtask

   task automatic start(input int op, input logic [RW-1:0] r, input logic [TW-1:0] t,
                        input logic [DW-1:0] rf);
      op_req = '0; op_pending = '0;
      dec_new        = 1'b1;
      op_req[op]     = 1'b1;
      op_pending[op] = 1'b1;
      op_reg[op]     = r;
      op_tag[op]     = t;
      rf_data[op]    = rf;
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=expired expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      op_req = '0; op_pending = '0; op_reg = '0; op_tag = '0;
      rf_data = '0;
      quiet();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      rf_data[0] = 16'h1234; rf_data[1] = 16'h5678;
      #1;
      chk("R1 reset", 0, 16'h1234, 1'b0);
      chk("R1 reset", 1, 16'h5678, 1'b0);

      // R1: no pending producer, or no request, passes rf through
      for (int op = 0; op < NO; op++) begin
         for (int r = 0; r < 8; r++) begin
            next();
            start(op, RW'(r), 3'd7, 16'hA000 + 16'(r));
            op_pending[op] = 1'b0;
            bus_valid = '1; bus_wen = '1; bus_reg = {NB{RW'(r)}}; bus_data = {NB{16'hDEAD}};
            #1 chk("R1 not pending", op, 16'hA000 + 16'(r), 1'b0);
            next();
            start(op, RW'(r), 3'd7, 16'hB000 + 16'(r));
            op_req[op] = 1'b0;
            #1 chk("R1 no request", op, 16'hB000 + 16'(r), 1'b0);
         end
      end

      // R2/R3/R4: register-number match sweep, all bus subsets, reg 0 included
      for (int op = 0; op < NO; op++) begin
         for (int r = 0; r < 8; r++) begin
            for (int m = 1; m < 8; m++) begin
               for (int pass = 0; pass < 2; pass++) begin
                  int young, old;
                  young = (m & 1) ? 0 : ((m & 2) ? 1 : 2);
                  old   = (m & 4) ? 2 : ((m & 2) ? 1 : 0);
                  next();
                  start(op, RW'(r), (pass == 0) ? 3'd7 : TW'(old), 16'hC000 + 16'(r));
                  for (int b = 0; b < NB; b++) begin
                     bus_valid[b] = 1'b1;
                     bus_wen[b]   = 1'b1;
                     bus_reg[b]   = m[b] ? RW'(r) : RW'(r ^ 1);
                     bus_tag[b]   = TW'(b);
                     bus_data[b]  = 16'(256 * (b + 1) + 16 * r + m);
                  end
                  #1 chk("R4 youngest match", op, 16'(256 * (young + 1) + 16 * r + m),
                         (pass == 0));
               end
            end
            // R2: tag equal but register differs -> no forward, still stalled
            next();
            start(op, RW'(r), 3'd1, 16'hE000 + 16'(r));
            for (int b = 0; b < NB; b++) begin
               bus_valid[b] = 1'b1; bus_wen[b] = 1'b1;
               bus_reg[b] = RW'(r ^ (b + 1)); bus_tag[b] = 3'd1; bus_data[b] = 16'hBAD0;
            end
            #1 chk("R2 tag only", op, 16'hE000 + 16'(r), 1'b1);
         end
      end

      // R5/R7/R9: first writer forwards, newer writer suppresses
      for (int op = 0; op < NO; op++) begin
         next(); start(op, 3'd5, 3'd2, 16'h1111);
         #1 chk("R6 initial stall", op, 16'h1111, 1'b1);
         next(); bus_valid[1] = 1; bus_wen[1] = 1; bus_reg[1] = 3'd5; bus_tag[1] = 3'd1;
         bus_data[1] = 16'hAAAA;
         #1 chk("R3 older forward", op, 16'hAAAA, 1'b1);
         next();
         #1 chk("R5 latched", op, 16'hAAAA, 1'b1);
         next(); bus_valid[0] = 1; bus_wen[0] = 0; bus_reg[0] = 3'd5; bus_tag[0] = 3'd2;
         bus_data[0] = 16'hBBBB;
         #1 chk("R7 suppressed no forward", op, 16'hAAAA, 1'b1);
         next(); cmp_valid = 1; cmp_tag = 3'd2; cmp_wen = 0;
         #1 chk("R7 suppressed completion", op, 16'hAAAA, 1'b0);
         next();
         #1 chk("R6 stays released", op, 16'hAAAA, 1'b0);

         // R10: new instruction discards latch and release
         next(); start(op, 3'd5, 3'd3, 16'h2222);
         #1 chk("R10 latch dropped", op, 16'h2222, 1'b1);
         next();
         #1 chk("R10 still stalled", op, 16'h2222, 1'b1);

         // R8: no-forward entry with matching tag
         next(); bus_valid[0] = 1; bus_wen[0] = 1; bus_slow[0] = 1; bus_reg[0] = 3'd5;
         bus_tag[0] = 3'd3; bus_data[0] = 16'hCCCC;
         #1 chk("R8 slow ignored", op, 16'h2222, 1'b1);
         next();
         #1 chk("R8 slow not latched", op, 16'h2222, 1'b1);
         next(); cmp_valid = 1; cmp_tag = 3'd3; cmp_wen = 1; rf_data[op] = 16'hCCCC;
         #1 chk("R9 completion writes", op, 16'hCCCC, 1'b0);
         next();
         #1 chk("R9 rf after completion", op, 16'hCCCC, 1'b0);

         // R9: latch from older writer must give way to written completion
         next(); start(op, 3'd0, 3'd4, 16'h3333);
         next(); bus_valid[2] = 1; bus_wen[2] = 1; bus_reg[2] = 3'd0; bus_tag[2] = 3'd6;
         bus_data[2] = 16'h4444;
         #1 chk("R2 reg0 forward", op, 16'h4444, 1'b1);
         next(); cmp_valid = 1; cmp_tag = 3'd4; cmp_wen = 1; rf_data[op] = 16'h5555;
         #1 chk("R9 written completion over latch", op, 16'h5555, 1'b0);
         next(); cmp_valid = 1; cmp_tag = 3'd4; cmp_wen = 0;
         #1 chk("R9 stays on rf", op, 16'h5555, 1'b0);

         // R6: recent producer forward releases and stays
         next(); start(op, 3'd6, 3'd5, 16'h6666);
         next(); bus_valid[0] = 1; bus_wen[0] = 1; bus_reg[0] = 3'd6; bus_tag[0] = 3'd5;
         bus_data[0] = 16'h7777;
         #1 chk("R6 recent forward releases", op, 16'h7777, 1'b0);
         next();
         #1 chk("R6 release held with latch", op, 16'h7777, 1'b0);
      end

      next();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule